// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar date as packed BCD bytes: seconds, minutes, hours, day of the week, day of the month, month and a two-digit year. A single-cycle `tick_i` pulse, produced elsewhere from the oscillator prescaler, advances the seconds. Carries then ripple through minutes, hours, date, month and year in the same clock edge. The day of the week advances on the same carry as the date, but its value does not depend on the date.

A host loads any one field per cycle through a select code and a data byte. All seven fields are visible at all times on the output bytes. The hours byte has two layouts. A mode bit selects a 12-hour clock with an AM/PM flag or a 24-hour clock. The date counter knows how long each month is and treats every year divisible by four as a leap year. That rule is correct for two-digit years up to 2099.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the fields read 00 seconds, 00 minutes, hour 0x00 (24-hour mode), weekday 01, date 01, month 01, year 00.
- R2: A host write stores `wr_data_i` into the field picked by `wr_sel_i` (0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year). Code 7 changes nothing. A write wins over a same-cycle tick increment of that field. Carries out of that field are still taken from its value before the write.
- R3: Bits a field does not use always read 0: bit 7 of seconds, minutes and hours; bits 7:3 of weekday; bits 7:6 of date; bits 7:5 of month. The year uses all 8 bits.
- R4: Seconds and minutes count in BCD 00–59. Each tick advances seconds, and a 59→00 wrap advances the next field.
- R5: With hours bit 6 = 0 (24-hour mode), hours count 00–23 in BCD with bits 5:4 as the tens digit. 23→00 advances date and weekday.
- R6: With hours bit 6 = 1 (12-hour mode), bit 5 is PM and bits 4:0 hold 01–12 in BCD. 11→12 toggles PM and 12→01 does not. Going from 11 PM to 12 AM advances date and weekday.
- R7: Weekday counts 1–7 and wraps 7→1 on every date advance, whatever the date is.
- R8: Months 04, 06, 09 and 11 end at date 30. Months 01, 03, 05, 07, 08, 10 and 12 end at 31. After the last date comes date 01 of the next month.
- R9: February ends at 29 when the year value is divisible by 4 (including 00), and at 28 otherwise.
- R10: Date 31 of month 12 rolls to 01/01 and advances the year. Year 99 wraps to 00.
- R11: With no tick and no write, no field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second advance enable, single cycle |
| wr_en_i | input | 1 | Field write strobe |
| wr_sel_i | input | 3 | Field select for writes |
| wr_data_i | input | 8 | Write data, packed BCD |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours with mode and PM bits |
| wday_o | output | 8 | Day of week |
| date_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Two-digit year |

## Verification
The bench loads the times just before the rollovers that matter: 28 and 29 February in leap years (00, 24) and in a non-leap year (23), the ends of 30-day months and of a 31-day month, 31 December 23:59:59 in year 99, and 11:59:59 on both sides of noon and midnight in 12-hour mode. If the leap rule were wrong, the date would jump to 1 March a day early or land on 29 February in year 23. A wrong month decode for 0x11 would reach date 31 in November. If the 12-hour logic toggled PM in the wrong place, 12 PM would become 01 AM, or midnight would not advance the date. The bench also writes a field in the same cycle as a tick, and writes bytes with the unused bits set. A design with the wrong priority would show the increment instead of the written value. One with bad masking would read back the stray high bits.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int FW     = 8;
  localparam int NFIELD = 7;
  localparam int SEL_W  = $clog2(NFIELD + 1);

  typedef enum logic [SEL_W-1:0] {
    SEL_SEC   = 3'd0,
    SEL_MIN   = 3'd1,
    SEL_HOUR  = 3'd2,
    SEL_WDAY  = 3'd3,
    SEL_DATE  = 3'd4,
    SEL_MONTH = 3'd5,
    SEL_YEAR  = 3'd6,
    SEL_NONE  = 3'd7
  } fsel_e;

  function automatic logic [FW-1:0] bcd_inc(input logic [FW-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input logic [FW-1:0] y);
    logic [6:0] b;
    b = ({3'b0, y[7:4]} * 7'd10) + {3'b0, y[3:0]};
    return b[1:0] == 2'b00;
  endfunction

  function automatic logic [FW-1:0] month_last(input logic [FW-1:0] m, input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [FW-1:0] field_mask(input logic [SEL_W-1:0] sel);
    case (sel)
      SEL_SEC, SEL_MIN, SEL_HOUR: return 8'h7F;
      SEL_WDAY:                   return 8'h07;
      SEL_DATE:                   return 8'h3F;
      SEL_MONTH:                  return 8'h1F;
      SEL_YEAR:                   return 8'hFF;
      default:                    return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/rtc_mod_cnt.sv
module rtc_mod_cnt
  import rtc_pkg::*;
#(
  parameter logic [FW-1:0] LO  = 8'h00,
  parameter logic [FW-1:0] HI  = 8'h59,
  parameter logic [FW-1:0] RST = 8'h00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          ld_i,
  input  logic [FW-1:0] ld_val_i,
  output logic [FW-1:0] val_o,
  output logic          wrap_o
);
  logic [FW-1:0] val_q;

  assign wrap_o = inc_i && (val_q == HI);
  assign val_o  = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_q <= RST;
    else if (ld_i)  val_q <= ld_val_i;
    else if (inc_i) val_q <= (val_q == HI) ? LO : bcd_inc(val_q);
  end
endmodule

// File: rtl/rtc_hour_cnt.sv
module rtc_hour_cnt
  import rtc_pkg::*;
#(
  parameter logic [FW-1:0] RST = 8'h00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          ld_i,
  input  logic [FW-1:0] ld_val_i,
  output logic [FW-1:0] hour_o,
  output logic          day_o
);
  logic [FW-1:0] hour_q, hour_d, inc12, inc24;
  logic          mode12, pm;

  assign mode12 = hour_q[6];
  assign pm     = hour_q[5];
  assign inc12  = bcd_inc({3'b0, hour_q[4:0]});
  assign inc24  = bcd_inc({2'b0, hour_q[5:0]});

  always_comb begin
    hour_d = hour_q;
    day_o  = 1'b0;
    if (mode12) begin
      if (hour_q[4:0] == 5'h11) begin
        hour_d = {2'b01, ~pm, 5'h12};
        day_o  = inc_i && pm;
      end else if (hour_q[4:0] == 5'h12) begin
        hour_d = {2'b01, pm, 5'h01};
      end else begin
        hour_d = {2'b01, pm, inc12[4:0]};
      end
    end else begin
      if (hour_q[5:0] == 6'h23) begin
        hour_d = 8'h00;
        day_o  = inc_i;
      end else begin
        hour_d = {2'b00, inc24[5:0]};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hour_q <= RST;
    else if (ld_i)  hour_q <= ld_val_i;
    else if (inc_i) hour_q <= hour_d;
  end

  assign hour_o = hour_q;
endmodule

// File: rtl/rtc_date_cnt.sv
module rtc_date_cnt
  import rtc_pkg::*;
#(
  parameter logic [FW-1:0] RST_DATE  = 8'h01,
  parameter logic [FW-1:0] RST_MONTH = 8'h01
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          leap_i,
  input  logic          ld_date_i,
  input  logic          ld_month_i,
  input  logic [FW-1:0] ld_val_i,
  output logic [FW-1:0] date_o,
  output logic [FW-1:0] month_o,
  output logic          year_inc_o
);
  logic [FW-1:0] date_q, month_q, last;
  logic          mon_wrap;

  assign last       = month_last(month_q, leap_i);
  assign mon_wrap   = inc_i && (date_q == last);
  assign year_inc_o = mon_wrap && (month_q == 8'h12);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        date_q <= RST_DATE;
    else if (ld_date_i) date_q <= ld_val_i;
    else if (inc_i)     date_q <= mon_wrap ? 8'h01 : bcd_inc(date_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         month_q <= RST_MONTH;
    else if (ld_month_i) month_q <= ld_val_i;
    else if (mon_wrap)   month_q <= (month_q == 8'h12) ? 8'h01 : bcd_inc(month_q);
  end

  assign date_o  = date_q;
  assign month_o = month_q;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter logic [FW-1:0] RST_HOUR  = 8'h00,
  parameter logic [FW-1:0] RST_WDAY  = 8'h01,
  parameter logic [FW-1:0] RST_DATE  = 8'h01,
  parameter logic [FW-1:0] RST_MONTH = 8'h01,
  parameter logic [FW-1:0] RST_YEAR  = 8'h00
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [FW-1:0]    wr_data_i,
  output logic [FW-1:0]    sec_o,
  output logic [FW-1:0]    min_o,
  output logic [FW-1:0]    hour_o,
  output logic [FW-1:0]    wday_o,
  output logic [FW-1:0]    date_o,
  output logic [FW-1:0]    month_o,
  output logic [FW-1:0]    year_o
);
  logic [NFIELD-1:0] ld;
  logic [FW-1:0]     wval;
  logic              sec_wrap, min_wrap, day_adv, year_inc, wday_wrap, year_wrap;

  for (genvar i = 0; i < NFIELD; i++) begin : g_ld
    assign ld[i] = wr_en_i && (wr_sel_i == SEL_W'(i));
  end

  assign wval = wr_data_i & field_mask(wr_sel_i);

  rtc_mod_cnt #(.LO(8'h00), .HI(8'h59), .RST(8'h00)) u_sec (
    .clk_i, .rst_ni, .inc_i(tick_i), .ld_i(ld[SEL_SEC]), .ld_val_i(wval),
    .val_o(sec_o), .wrap_o(sec_wrap)
  );

  rtc_mod_cnt #(.LO(8'h00), .HI(8'h59), .RST(8'h00)) u_min (
    .clk_i, .rst_ni, .inc_i(sec_wrap), .ld_i(ld[SEL_MIN]), .ld_val_i(wval),
    .val_o(min_o), .wrap_o(min_wrap)
  );

  rtc_hour_cnt #(.RST(RST_HOUR)) u_hour (
    .clk_i, .rst_ni, .inc_i(min_wrap), .ld_i(ld[SEL_HOUR]), .ld_val_i(wval),
    .hour_o, .day_o(day_adv)
  );

  // weekday shares the day carry but not the date value
  rtc_mod_cnt #(.LO(8'h01), .HI(8'h07), .RST(RST_WDAY)) u_wday (
    .clk_i, .rst_ni, .inc_i(day_adv), .ld_i(ld[SEL_WDAY]), .ld_val_i(wval),
    .val_o(wday_o), .wrap_o(wday_wrap)
  );

  rtc_date_cnt #(.RST_DATE(RST_DATE), .RST_MONTH(RST_MONTH)) u_date (
    .clk_i, .rst_ni, .inc_i(day_adv), .leap_i(is_leap(year_o)),
    .ld_date_i(ld[SEL_DATE]), .ld_month_i(ld[SEL_MONTH]), .ld_val_i(wval),
    .date_o, .month_o, .year_inc_o(year_inc)
  );

  rtc_mod_cnt #(.LO(8'h00), .HI(8'h99), .RST(RST_YEAR)) u_year (
    .clk_i, .rst_ni, .inc_i(year_inc), .ld_i(ld[SEL_YEAR]), .ld_val_i(wval),
    .val_o(year_o), .wrap_o(year_wrap)
  );

  logic unused_wraps;
  assign unused_wraps = wday_wrap ^ year_wrap;
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             wr_en_i,
  input logic [SEL_W-1:0] wr_sel_i,
  input logic [FW-1:0]    wr_data_i,
  input logic [FW-1:0]    sec_o,
  input logic [FW-1:0]    min_o,
  input logic [FW-1:0]    hour_o,
  input logic [FW-1:0]    wday_o,
  input logic [FW-1:0]    date_o,
  input logic [FW-1:0]    month_o,
  input logic [FW-1:0]    year_o
);
  assert_unused_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_o[7] == 1'b0) && (min_o[7] == 1'b0) && (hour_o[7] == 1'b0) &&
    (wday_o[7:3] == 5'b0) && (date_o[7:6] == 2'b0) && (month_o[7:5] == 3'b0));

  assert_write_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_SEC) |=> (sec_o == ($past(wr_data_i) & 8'h7F)));

  assert_sec_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_en_i && sec_o == 8'h59) |=> (sec_o == 8'h00));

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_en_i) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
      $stable(wday_o) && $stable(date_o) && $stable(month_o) && $stable(year_o)));

  assert_hour12_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hour_o[6] |-> (hour_o[4:0] != 5'h00 && hour_o[4:0] <= 5'h12));

  assert_wday_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wday_o != 8'h00 && wday_o <= 8'h07));

  assert_date_nonzero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (date_o != 8'h00));

  assert_month_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (month_o != 8'h00 && month_o <= 8'h12));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (.*);

// File: tb/sim_rtc_calendar.sv
`timescale 1ns/1ps
module sim_rtc_calendar;
  import rtc_pkg::*;

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec, min, hour, wday, date, month, year;

  always #4 clk = ~clk;  // 125 MHz

  rtc_calendar u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .sec_o(sec), .min_o(min), .hour_o(hour), .wday_o(wday),
    .date_o(date), .month_o(month), .year_o(year)
  );

  typedef struct { logic [55:0] val; string req; } exp_t;
  exp_t q[$];
  logic [7:0] e [7];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic step(input bit t, input bit w, input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); tick = t; wr_en = w; wr_sel = s; wr_data = d;
    @(posedge clk); #1; tick = 1'b0; wr_en = 1'b0;
  endtask

  task automatic ld(input logic [2:0] s, input logic [7:0] d, input logic [7:0] ev);
    step(1'b0, 1'b1, s, d);
    if (s < 3'd7) e[s] = ev;
  endtask

  task automatic tk();
    step(1'b1, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic chk(input string r);
    exp_t x;
    x.val = {e[6], e[5], e[4], e[3], e[2], e[1], e[0]};
    x.req = r;
    q.push_back(x);
  endtask

  task automatic set_last_second(input logic [7:0] h);
    ld(3'd2, h, h & 8'h7F);
    ld(3'd1, 8'h59, 8'h59);
    ld(3'd0, 8'h59, 8'h59);
  endtask

  task automatic set_day(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d);
    ld(3'd6, y, y);
    ld(3'd5, mo, mo);
    ld(3'd4, d, d);
  endtask

  // monitor: pops expected snapshots and compares at the falling edge
  always @(negedge clk) begin
    exp_t x;
    logic [55:0] act;
    if (q.size() > 0) begin
      x = q.pop_front();
      act = {year, month, date, wday, hour, min, sec};
      n_cmp++;
      if (act !== x.val) begin
        n_bad++;
        $display("FAIL %s actual=%h expected=%h (y mo d wd h m s)", x.req, act, x.val);
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    e[0] = 8'h00; e[1] = 8'h00; e[2] = 8'h00; e[3] = 8'h01;
    e[4] = 8'h01; e[5] = 8'h01; e[6] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 3'd0, 8'h00);
    chk("R1 reset values");
    repeat (3) step(1'b0, 1'b0, 3'd0, 8'h00);
    chk("R11 idle hold");
    ld(3'd7, 8'hFF, 8'h00);
    chk("R2 select 7 ignored");

    // masked loads, then new-year rollover from 99
    ld(3'd0, 8'hD9, 8'h59);
    ld(3'd1, 8'h59, 8'h59);
    ld(3'd2, 8'hA3, 8'h23);
    ld(3'd3, 8'hF7, 8'h07);
    ld(3'd4, 8'hF1, 8'h31);
    ld(3'd5, 8'hF2, 8'h12);
    ld(3'd6, 8'h99, 8'h99);
    chk("R3 unused bits masked on load");
    tk();
    e = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
    chk("R10 31 Dec 23:59:59 year 99 rollover");

    // write priority over tick
    ld(3'd0, 8'h59, 8'h59);
    ld(3'd1, 8'h10, 8'h10);
    step(1'b1, 1'b1, 3'd0, 8'h30);
    e[0] = 8'h30; e[1] = 8'h11;
    chk("R2 seconds write beats tick, carry from old value");
    step(1'b1, 1'b1, 3'd1, 8'h45);
    e[0] = 8'h31; e[1] = 8'h45;
    chk("R2 minutes write beats tick");

    // BCD carries
    ld(3'd0, 8'h09, 8'h09);
    tk(); e[0] = 8'h10;
    chk("R4 seconds units carry");
    set_last_second(8'h05);
    tk(); e[0] = 8'h00; e[1] = 8'h00; e[2] = 8'h06;
    chk("R4 minute and hour carry");
    set_last_second(8'h19);
    tk(); e[0] = 8'h00; e[1] = 8'h00; e[2] = 8'h20;
    chk("R5 24-hour 19 to 20");

    // leap year 00
    set_day(8'h00, 8'h02, 8'h28);
    ld(3'd3, 8'h03, 8'h03);
    set_last_second(8'h23);
    tk(); e[0] = 8'h00; e[1] = 8'h00; e[2] = 8'h00; e[3] = 8'h04; e[4] = 8'h29;
    chk("R9 year 00 Feb 28 to 29");
    set_last_second(8'h23);
    tk(); e[0] = 8'h00; e[1] = 8'h00; e[2] = 8'h00; e[3] = 8'h05; e[4] = 8'h01; e[5] = 8'h03;
    chk("R9 year 00 Feb 29 to Mar 01");

    // non-leap year 23
    set_day(8'h23, 8'h02, 8'h28);
    set_last_second(8'h23);
    tk(); e[0] = 8'h00; e[1] = 8'h00; e[2] = 8'h00; e[3] = 8'h06; e[4] = 8'h01; e[5] = 8'h03;
    chk("R9 year 23 Feb 28 to Mar 01");

    // leap year 24
    set_day(8'h24, 8'h02, 8'h28);
    set_last_second(8'h23);
    tk(); e[0] = 8'h00; e[1] = 8'h00; e[2] = 8'h00; e[3] = 8'h07; e[4] = 8'h29;
    chk("R9 year 24 Feb 28 to 29");
    set_last_second(8'h23);
    tk(); e[0] = 8'h00; e[1] = 8'h00; e[2] = 8'h00; e[3] = 8'h01; e[4] = 8'h01; e[5] = 8'h03;
    chk("R7 weekday 7 to 1 with Mar 01");

    // month lengths
    set_day(8'h24, 8'h04, 8'h30);
    set_last_second(8'h23);
    tk(); e[0] = 8'h00; e[1] = 8'h00; e[2] = 8'h00; e[3] = 8'h02; e[4] = 8'h01; e[5] = 8'h05;
    chk("R8 April 30 to May 01");
    ld(3'd4, 8'h30, 8'h30);
    set_last_second(8'h23);
    tk(); e[0] = 8'h00; e[1] = 8'h00; e[2] = 8'h00; e[3] = 8'h03; e[4] = 8'h31;
    chk("R8 May 30 to 31");
    set_last_second(8'h23);
    tk(); e[0] = 8'h00; e[1] = 8'h00; e[2] = 8'h00; e[3] = 8'h04; e[4] = 8'h01; e[5] = 8'h06;
    chk("R8 May 31 to Jun 01");
    set_day(8'h24, 8'h11, 8'h30);
    set_last_second(8'h23);
    tk(); e[0] = 8'h00; e[1] = 8'h00; e[2] = 8'h00; e[3] = 8'h05; e[4] = 8'h01; e[5] = 8'h12;
    chk("R8 November 30 to Dec 01");

    // 12-hour mode
    set_last_second(8'hF1);
    chk("R3 hour mask in 12-hour load");
    tk(); e[0] = 8'h00; e[1] = 8'h00; e[2] = 8'h52; e[3] = 8'h06; e[4] = 8'h02;
    chk("R6 11 PM to 12 AM advances date");
    set_last_second(8'h51);
    tk(); e[0] = 8'h00; e[1] = 8'h00; e[2] = 8'h72;
    chk("R6 11 AM to 12 PM no date change");
    ld(3'd1, 8'h59, 8'h59);
    ld(3'd0, 8'h59, 8'h59);
    tk(); e[0] = 8'h00; e[1] = 8'h00; e[2] = 8'h61;
    chk("R6 12 PM to 01 PM keeps PM");
    set_last_second(8'h52);
    tk(); e[0] = 8'h00; e[1] = 8'h00; e[2] = 8'h41;
    chk("R6 12 AM to 01 AM");
    repeat (2) step(1'b0, 1'b0, 3'd0, 8'h00);
    chk("R11 idle hold after 12-hour tests");

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule